// File: doc/BRIEF.md
# Repeater Identification Interval Controller

This block decides when a repeater must send its station identification. It watches three inputs: a repeater-activity level, a page-inhibit level and a manual test-start. It tells an external message sender when to begin (`msgStart`) and learns from it when the message is over (`msgDone`). While a message is being sent it holds the transmitter-key output high, so the transmitter is on the air even when the repeater itself is quiet.

The first burst of activity from idle causes one identification at once. During the message, and for a fixed guard window after it ends, activity is ignored. Activity seen after the guard window arms a repeat, which is sent when the interval timer expires. If the interval passes with no armed activity, the block goes back to idle. The interval timer counts a slow tick (one clock-wide enable pulse, nominally 60 Hz) up to `BASE_DIV` ticks scaled by 1, 2, 4 or 8. The guard window does not change with that scale. A page-inhibit held at expiry delays the repeat until it is released. A test-start edge launches a message whatever the timer is doing.

Top module: `repeater_id_ctrl`

## Requirements
- R1: With the block idle, activity held high for at least two clocks makes `msgStart` pulse for exactly one clock, 3 clock edges after the input change.
- R2: `txKey` is high from the cycle `msgStart` pulses up to and including the cycle `msgDone` is seen, then low on the next cycle: DUR+1 cycles for a sender that answers DUR cycles after the start.
- R3: Activity seen while a message is being sent, or within `GUARD_TICKS` ticks after `msgDone`, is ignored: no repeat follows, and the block returns to idle at interval end.
- R4: Activity seen after the guard window causes a repeat start when the interval expires. The interval is (`BASE_DIV` << `intervalSel`) ticks counted from the previous `msgStart`, with `intervalSel` = 0, 1, 2, 3 giving a scale of 1, 2, 4, 8.
- R5: Activity held high without a break produces one identification per interval for as long as it lasts.
- R6: If `pageIn` is high when the interval expires with activity armed, no start is issued while it stays high. The start comes 3 edges after it is released.
- R7: `pageIn` does not affect the interval timer. A page that is released before expiry leaves the repeat at its normal time.
- R8: A rising edge on `testIn` starts a message 3 edges later in any state except while a message is being sent. Test edges during a message are ignored.
- R9: After an interval with no armed activity, the block is idle: the timer is reset and new activity starts a message at once.
- R10: `msgStart` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-clock timebase enable pulse (mains or local 60 Hz) |
| activityIn | input | 1 | Repeater activity level, asynchronous |
| pageIn | input | 1 | Page-inhibit level, asynchronous |
| testIn | input | 1 | Manual test-start, asynchronous, rising edge acts |
| intervalSel | input | 2 | Interval scale: 0=x1, 1=x2, 2=x4, 3=x8 |
| msgDone | input | 1 | One-clock pulse from the sender at message end |
| msgStart | output | 1 | One-clock pulse telling the sender to begin |
| txKey | output | 1 | Transmitter key, high for the whole message |

## Verification
Each asynchronous input passes through two synchroniser flops, and the start decision is then registered. A start caused by activity, a test edge or a page release therefore shows on `msgStart` exactly 3 clock edges after the input change, and the bench samples on that edge count after its drive. A repeat is due a whole number of ticks after the previous start, but the tick phase and the output register leave a few cycles of slack. Interval checks therefore compare the measured cycle gap against a window from 4·limit−3 to 4·limit+2 cycles for the bench's tick period of 4. The key length is checked exactly against the sender's answer delay plus one.

// File: rtl/idctl_pkg.sv
package idctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_HOLD = 2'd3
  } ctlState_t;

  typedef struct packed {
    logic clrInterval;
    logic runInterval;
    logic loadGuard;
    logic clrSense;
    logic sending;
  } ctlStrobe_t;

endpackage

// File: rtl/id_sync.sv
module id_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0] chain [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[b] <= '0;
      else       chain[b] <= {chain[b][STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[b][STAGES-1];
  end

endmodule

// File: rtl/id_datapath.sv
module id_datapath
  import idctl_pkg::*;
#(
  parameter int BASE_DIV    = 10240,
  parameter int GUARD_TICKS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       actSync,
  input  logic [1:0] intervalSel,
  input  ctlStrobe_t strobe,
  output logic       expired,
  output logic       senseSet
);

  localparam int MAX_LIMIT = BASE_DIV * 8;
  localparam int CNT_W     = $clog2(MAX_LIMIT + 1);
  localparam int GRD_W     = $clog2(GUARD_TICKS + 1);

  logic [CNT_W-1:0] intervalCnt;
  logic [CNT_W-1:0] limitVal;
  logic [GRD_W-1:0] guardCnt;
  logic             blocked;

  assign limitVal = CNT_W'(BASE_DIV) << intervalSel;
  assign expired  = (intervalCnt >= limitVal);
  assign blocked  = strobe.sending || (guardCnt != '0);

  // interval timer: cleared while idle or at a start, saturates at limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  intervalCnt <= '0;
    else if (strobe.clrInterval)                intervalCnt <= '0;
    else if (strobe.runInterval && tickEn && !expired)
                                                intervalCnt <= intervalCnt + 1'b1;
  end

  // guard window after each message, in ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        guardCnt <= '0;
    else if (strobe.loadGuard)        guardCnt <= GRD_W'(GUARD_TICKS);
    else if (tickEn && guardCnt != 0) guardCnt <= guardCnt - 1'b1;
  end

  // activity-sense latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     senseSet <= 1'b0;
    else if (strobe.clrSense)      senseSet <= 1'b0;
    else if (actSync && !blocked)  senseSet <= 1'b1;
  end

  // R3
  guard_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blocked && !senseSet) |=> !senseSet);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    intervalCnt <= CNT_W'(MAX_LIMIT));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrInterval && !tickEn) |=> $stable(intervalCnt));

endmodule

// File: rtl/id_control.sv
module id_control
  import idctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       actSync,
  input  logic       pageSync,
  input  logic       testSync,
  input  logic       msgDone,
  input  logic       expired,
  input  logic       senseSet,
  output ctlStrobe_t strobe,
  output logic       msgStart,
  output logic       txKey
);

  ctlState_t state, stateNext;
  logic      testPrev;
  logic      testRise;
  logic      startNow;

  assign testRise = testSync && !testPrev;

  always_comb begin
    startNow = 1'b0;
    if (state != ST_SEND) begin
      startNow = testRise;
      case (state)
        ST_IDLE: if (actSync) startNow = 1'b1;
        ST_WAIT: if (expired && senseSet && !pageSync) startNow = 1'b1;
        ST_HOLD: if (!pageSync) startNow = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    stateNext = state;
    if (startNow) stateNext = ST_SEND;
    else begin
      case (state)
        ST_SEND: if (msgDone) stateNext = ST_WAIT;
        ST_WAIT: if (expired) stateNext = senseSet ? ST_HOLD : ST_IDLE;
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.clrInterval = startNow || (state == ST_IDLE);
    strobe.runInterval = (state == ST_SEND) || (state == ST_WAIT);
    strobe.loadGuard   = (state == ST_SEND) && msgDone;
    strobe.clrSense    = startNow;
    strobe.sending     = (state == ST_SEND);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      testPrev <= 1'b0;
      msgStart <= 1'b0;
    end else begin
      state    <= stateNext;
      testPrev <= testSync;
      msgStart <= startNow;
    end
  end

  assign txKey = (state == ST_SEND);

  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgStart |=> !msgStart);

  // R2
  key_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgStart |-> txKey);

  // R2
  key_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txKey && msgDone) |=> !txKey);

  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && pageSync && !testRise) |=> !msgStart);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txKey && !msgDone) |=> !msgStart);

endmodule

// File: rtl/repeater_id_ctrl.sv
module repeater_id_ctrl
  import idctl_pkg::*;
#(
  parameter int BASE_DIV    = 10240,
  parameter int GUARD_TICKS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       activityIn,
  input  logic       pageIn,
  input  logic       testIn,
  input  logic [1:0] intervalSel,
  input  logic       msgDone,
  output logic       msgStart,
  output logic       txKey
);

  logic [2:0] syncBus;
  ctlStrobe_t strobe;
  logic       expired;
  logic       senseSet;

  id_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({testIn, pageIn, activityIn}),
    .syncOut (syncBus)
  );

  id_datapath #(.BASE_DIV(BASE_DIV), .GUARD_TICKS(GUARD_TICKS)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .actSync     (syncBus[0]),
    .intervalSel (intervalSel),
    .strobe      (strobe),
    .expired     (expired),
    .senseSet    (senseSet)
  );

  id_control i_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .actSync  (syncBus[0]),
    .pageSync (syncBus[1]),
    .testSync (syncBus[2]),
    .msgDone  (msgDone),
    .expired  (expired),
    .senseSet (senseSet),
    .strobe   (strobe),
    .msgStart (msgStart),
    .txKey    (txKey)
  );

endmodule

// File: tb/test_repeater_id_ctrl.sv
module test_repeater_id_ctrl;

  localparam int BASE = 32;
  localparam int GRD  = 4;
  localparam int TPER = 4;
  localparam int DUR  = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       activityIn = 1'b0;
  logic       pageIn = 1'b0;
  logic       testIn = 1'b0;
  logic [1:0] intervalSel = 2'd0;
  logic       msgDone = 1'b0;
  logic       msgStart;
  logic       txKey;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int startCount = 0;
  int prevStart = 0;
  int lastGap = 0;
  int keyRun = 0;
  int rem = 0;

  always #4 clk = ~clk;

  repeater_id_ctrl #(.BASE_DIV(BASE), .GUARD_TICKS(GRD)) i_repeater_id_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .activityIn(activityIn),
    .pageIn(pageIn), .testIn(testIn), .intervalSel(intervalSel),
    .msgDone(msgDone), .msgStart(msgStart), .txKey(txKey)
  );

  // monitor and sender model, both on the falling edge
  always @(negedge clk) begin
    cyc++;
    tickEn <= ((cyc % TPER) == 0);
    if (msgStart) begin
      startCount++;
      lastGap = cyc - prevStart;
      prevStart = cyc;
      keyRun = 0;
    end
    if (txKey) keyRun++;
    if (msgDone) msgDone <= 1'b0;
    if (msgStart) rem = DUR;
    else if (rem > 0) begin
      rem--;
      if (rem == 0) msgDone <= 1'b1;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  task automatic nextCyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitStart(int maxCyc, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < maxCyc && !seen; i++) begin
      nextCyc();
      if (msgStart) seen = 1'b1;
    end
  endtask

  task automatic waitKeyLow();
    for (int i = 0; i < 200 && txKey; i++) nextCyc();
  endtask

  initial begin
    bit seen;
    int base;
    int lim;
    nextCyc(5);
    rstN = 1'b1;
    nextCyc(3);
    check(msgStart == 1'b0 && txKey == 1'b0, "reset R1", int'(msgStart), 0);

    // R1, R2, R3 (activity during message), R9
    activityIn = 1'b1;
    nextCyc(2);
    check(msgStart == 1'b0, "R1 early", int'(msgStart), 0);
    nextCyc();
    check(msgStart == 1'b1, "R1 start", int'(msgStart), 1);
    check(txKey == 1'b1, "R2 key at start", int'(txKey), 1);
    nextCyc();
    check(msgStart == 1'b0, "R10 one-cycle", int'(msgStart), 0);
    nextCyc(10);
    activityIn = 1'b0;
    base = startCount;
    waitKeyLow();
    check(keyRun == DUR + 1, "R2 key length", keyRun, DUR + 1);
    nextCyc(BASE * TPER + 60);
    check(startCount == base, "R3 no repeat after message-only activity", startCount, base);
    activityIn = 1'b1;
    nextCyc(3);
    check(msgStart == 1'b1, "R9 idle restart", int'(msgStart), 1);
    activityIn = 1'b0;
    waitKeyLow();

    // R3: activity inside the guard window
    activityIn = 1'b1; nextCyc(2); activityIn = 1'b0;
    nextCyc(BASE * TPER + 60);
    base = startCount;
    activityIn = 1'b1; waitStart(10, seen); activityIn = 1'b0;
    check(seen, "R9 start from idle", int'(seen), 1);
    waitKeyLow();
    activityIn = 1'b1; nextCyc(6); activityIn = 1'b0;
    nextCyc(BASE * TPER + 60);
    check(startCount == base + 1, "R3 guard activity ignored", startCount, base + 1);

    // R4, R5: sweep the interval scale with continuous activity
    for (int sel = 0; sel < 4; sel++) begin
      intervalSel = 2'(sel);
      lim = (BASE << sel) * TPER;
      activityIn = 1'b1;
      waitStart(10, seen);
      check(seen, "R1 sweep first start", int'(seen), 1);
      for (int r = 0; r < 2; r++) begin
        waitStart(lim + 40, seen);
        check(seen && lastGap >= lim - 3 && lastGap <= lim + 2,
              (r == 0) ? "R4 interval gap" : "R5 repeated gap", lastGap, lim);
      end
      activityIn = 1'b0;
      base = startCount;
      nextCyc(lim + 60);
      check(startCount == base, "R9 returns idle", startCount, base);
    end
    intervalSel = 2'd0;
    lim = BASE * TPER;

    // R6: page held at expiry
    activityIn = 1'b1; waitStart(10, seen); activityIn = 1'b0;
    waitKeyLow();
    nextCyc(40);
    activityIn = 1'b1; nextCyc(8); activityIn = 1'b0;
    pageIn = 1'b1;
    base = startCount;
    nextCyc(lim + 100);
    check(startCount == base, "R6 held while paging", startCount, base);
    pageIn = 1'b0;
    nextCyc(2);
    check(msgStart == 1'b0, "R6 not before sync", int'(msgStart), 0);
    nextCyc();
    check(msgStart == 1'b1, "R6 start after release", int'(msgStart), 1);
    waitKeyLow();
    nextCyc(lim + 60);

    // R7: page released before expiry does not shift the timer
    activityIn = 1'b1; waitStart(10, seen); activityIn = 1'b0;
    pageIn = 1'b1;
    waitKeyLow();
    nextCyc(40);
    activityIn = 1'b1; nextCyc(8); activityIn = 1'b0;
    nextCyc(20);
    pageIn = 1'b0;
    waitStart(lim + 40, seen);
    check(seen && lastGap >= lim - 3 && lastGap <= lim + 2, "R7 timer unaffected", lastGap, lim);
    waitKeyLow();
    nextCyc(lim + 60);

    // R8: test start from idle, during a message, and inside the guard
    testIn = 1'b1;
    nextCyc(3);
    check(msgStart == 1'b1, "R8 test from idle", int'(msgStart), 1);
    nextCyc(2); testIn = 1'b0;
    nextCyc(4);
    base = startCount;
    testIn = 1'b1; nextCyc(4); testIn = 1'b0;
    waitKeyLow();
    check(startCount == base, "R8 test ignored while sending", startCount, base);
    nextCyc(2);
    testIn = 1'b1;
    nextCyc(3);
    check(msgStart == 1'b1, "R8 test inside guard", int'(msgStart), 1);
    testIn = 1'b0;
    waitKeyLow();
    nextCyc(lim + 60);

    summary();
  end

endmodule